// File: doc/BRIEF.md
# GPIO Event Detector with Interrupt Combiner

This block watches a vector of resolved pin input levels and records events in a sticky status register, one bit per pin. Each bit picks its own sensing mode. It can record a high level, a rising transition, or a transition in either direction. Software clears recorded events by writing ones to the matching status bits. An enable mask selects the status bits that drive a single interrupt line.

A register file alongside the block holds the mode selects and the enable mask and presents them as plain vectors. A write strobe with data is the only path for clearing status. The block keeps a registered copy of the previous input vector for edge detection. For the first clock after reset it treats that copy as not yet valid, so a pin that is already high at reset is not recorded as an edge.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset, status reads 0 and irq is 0. In the first clock after reset is released, no edge is recorded, whatever level the inputs hold.
- R2: A bit with its type select (evtyp) at 0 is in level mode. On every clock where din for that bit is 1, its status bit is set. The bit stays set after din falls, until software clears it.
- R3: A bit with evtyp 1 and evbe 0 is in rising-edge mode. Its status bit is set only when din goes from 0 to 1 between two clocks. A 1-to-0 change leaves it untouched.
- R4: A bit with evtyp 1 and evbe 1 is in both-edge mode. Any change of din between two clocks sets its status bit. A steady input sets nothing.
- R5: When st_wr is 1 on a clock, each status bit whose st_wdata bit is 1 is cleared, and each status bit whose st_wdata bit is 0 keeps its value.
- R6: When a clear and a new event hit the same bit on the same clock, the bit ends up set. This holds for a level that is still high and for a fresh edge.
- R7: irq is 1 exactly when some bit is 1 in both status and even. irq is combinational, so it follows a change of even without waiting for a clock edge.
- R8: The mode selects act bit by bit, so level, rising and both-edge bits can be mixed in one vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | WIDTH | Resolved pin input levels |
| evtyp | input | WIDTH | Per-bit type select: 0 for level, 1 for edge |
| evbe | input | WIDTH | Per-bit select that adds falling edges in edge mode |
| even | input | WIDTH | Per-bit interrupt enable |
| st_wr | input | 1 | Status clear strobe |
| st_wdata | input | WIDTH | Write-one-to-clear mask for status |
| status | output | WIDTH | Sticky event status |
| irq | output | 1 | Interrupt, OR of status masked by even |

## Verification
Two functions can fall on the same clock: a write-one clear of a status bit, and a new event on that same bit. The bench provokes this twice. In level mode it clears a bit whose input is held high. In both-edge mode it clears a bit in the same cycle that its input rises. Each time it checks that the bit reads set one clock later, while bits cleared in the same write without a new event read zero.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

   typedef enum logic [1:0] {
      SENSE_LEVEL = 2'd0,
      SENSE_RISE  = 2'd1,
      SENSE_ANY   = 2'd2
   } sense_e;

   // Per-bit mode decode; when both-edge support is compiled out the
   // select falls back to rising only.
   function automatic sense_e decode_sense(input logic typ, input logic be,
                                           input bit both_ok);
      sense_e m;
      if (!typ)
         m = SENSE_LEVEL;
      else if (be && both_ok)
         m = SENSE_ANY;
      else
         m = SENSE_RISE;
      return m;
   endfunction

endpackage

// File: rtl/gpio_evt_sense.sv
module gpio_evt_sense
   import gpio_evt_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit BOTH_EDGE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   input  logic [WIDTH-1:0] evtyp,
   input  logic [WIDTH-1:0] evbe,
   output logic [WIDTH-1:0] hit
);

   logic [WIDTH-1:0] prev_q;
   logic             armed_q;

   // The previous-sample copy is only trusted once it has been loaded
   // from din after reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= din;
         armed_q <= 1'b1;
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      sense_e mode;
      logic   rise;
      logic   fall;
      always_comb begin
         mode = decode_sense(evtyp[i], evbe[i], BOTH_EDGE_EN);
         rise = armed_q & din[i] & ~prev_q[i];
         fall = armed_q & ~din[i] & prev_q[i];
         unique case (mode)
            SENSE_LEVEL: hit[i] = din[i];
            SENSE_RISE:  hit[i] = rise;
            SENSE_ANY:   hit[i] = rise | fall;
            default:     hit[i] = 1'b0;
         endcase
      end
   end

   // R1: no edge is reported before the previous sample is valid
   p_first_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> ((hit & evtyp) == '0));

   // R4: a steady input raises no edge event
   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && din == prev_q) |-> ((hit & evtyp) == '0));

   // R3: a falling input never hits a rising-only bit
   p_rise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit & evtyp & ~evbe & ~din) == '0));

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hit,
   input  logic             st_wr,
   input  logic [WIDTH-1:0] st_wdata,
   output logic [WIDTH-1:0] status
);

   logic [WIDTH-1:0] clr_mask;
   logic [WIDTH-1:0] st_q;
   logic [WIDTH-1:0] st_d;

   assign clr_mask = st_wr ? st_wdata : '0;
   // New events are ORed in after the clear, so they win a collision.
   assign st_d     = (st_q & ~clr_mask) | hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= '0;
      else
         st_q <= st_d;
   end

   assign status = st_q;

   // R6: every event present on a clock is recorded
   p_hit_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((status & $past(hit)) == $past(hit)));

   // R5: written ones without a new event are cleared
   p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((status & $past(clr_mask & ~hit)) == '0));

   // R2: bits not written keep a set value
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((status & $past(status & ~clr_mask)) == $past(status & ~clr_mask)));

endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] status,
   input  logic [WIDTH-1:0] even,
   output logic             irq
);

   logic [WIDTH-1:0] pend;

   assign pend = status & even;
   assign irq  = |pend;

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
   parameter int WIDTH        = 32,
   parameter bit BOTH_EDGE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   input  logic [WIDTH-1:0] evtyp,
   input  logic [WIDTH-1:0] evbe,
   input  logic [WIDTH-1:0] even,
   input  logic             st_wr,
   input  logic [WIDTH-1:0] st_wdata,
   output logic [WIDTH-1:0] status,
   output logic             irq
);

   if (WIDTH < 1 || WIDTH > 1024) begin : g_bad_width
      $error("gpio_evt_unit: WIDTH out of range");
   end

   logic [WIDTH-1:0] hit;

   gpio_evt_sense #(.WIDTH(WIDTH), .BOTH_EDGE_EN(BOTH_EDGE_EN)) u_sense (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din),
      .evtyp (evtyp),
      .evbe  (evbe),
      .hit   (hit)
   );

   gpio_evt_status #(.WIDTH(WIDTH)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .st_wr    (st_wr),
      .st_wdata (st_wdata),
      .status   (status)
   );

   gpio_evt_irq #(.WIDTH(WIDTH)) u_irq (
      .status (status),
      .even   (even),
      .irq    (irq)
   );

   // R7: with every enable off the interrupt is quiet
   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (even == '0) |-> !irq);

endmodule

// File: tb/gpio_evt_unit_test.sv
module gpio_evt_unit_test;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] din = '0, evtyp = '0, evbe = '0, even = '0, st_wdata = '0;
   logic         st_wr = 1'b0;
   logic [W-1:0] status;
   logic         irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   gpio_evt_unit #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .din(din), .evtyp(evtyp), .evbe(evbe),
      .even(even), .st_wr(st_wr), .st_wdata(st_wdata),
      .status(status), .irq(irq)
   );

   typedef struct packed {
      logic [31:0] typ;
      logic [31:0] be;
      logic [31:0] d;
      logic        wr;
      logic [31:0] wd;
      logic [31:0] en;
      logic [31:0] st;
      logic        iq;
   } vec_t;

   localparam int NV = 23;
   localparam logic [31:0] F = 32'hFFFF_FFFF;
   localparam vec_t TBL [NV] = '{
      '{F, F, 32'hFFFF0000, 1'b0, 32'h0,        32'h0, 32'h00000000, 1'b0},
      '{F, F, 32'hFF00FF00, 1'b0, 32'h0,        32'h0, 32'h00FFFF00, 1'b0},
      '{F, F, 32'hEF00FF08, 1'b0, 32'h0,        32'h0, 32'h10FFFF08, 1'b0},
      '{F, F, 32'hEF00FF08, 1'b1, 32'h0000F000, 32'h0, 32'h10FF0F08, 1'b0},
      '{F, F, 32'hEF00FF08, 1'b1, 32'h10FF0F08, 32'h0, 32'h00000000, 1'b0},
      '{F, 32'h0, 32'hFF00FF00, 1'b0, 32'h0,    32'h0, 32'h10000000, 1'b0},
      '{F, 32'h0, 32'h00FF0000, 1'b1, 32'h10000000, 32'h0, 32'h00FF0000, 1'b0},
      '{F, 32'h0, 32'h00FF0000, 1'b1, F,        32'h0, 32'h00000000, 1'b0},
      '{32'h0, 32'h0, 32'hBA987654, 1'b0, 32'h0, 32'h0, 32'hBA987654, 1'b0},
      '{32'h0, 32'h0, 32'h00000000, 1'b0, 32'h0, 32'h0, 32'hBA987654, 1'b0},
      '{32'h0, 32'h0, 32'h00000000, 1'b1, 32'h00007654, 32'h0, 32'hBA980000, 1'b0},
      '{32'h0, 32'h0, 32'h00000001, 1'b1, 32'h00000001, 32'h0, 32'hBA980001, 1'b0},
      '{32'h0, 32'h0, 32'h00000000, 1'b1, F,    32'h0, 32'h00000000, 1'b0},
      '{32'h0, 32'h0, 32'h00008000, 1'b0, 32'h0, 32'h0, 32'h00008000, 1'b0},
      '{32'h0, 32'h0, 32'h00008000, 1'b0, 32'h0, F,     32'h00008000, 1'b1},
      '{32'h0, 32'h0, 32'h00000200, 1'b1, 32'h00008000, F, 32'h00000200, 1'b1},
      '{32'h0, 32'h0, 32'h00000200, 1'b0, 32'h0, 32'hFFFFFDFF, 32'h00000200, 1'b0},
      '{32'h0, 32'h0, 32'h00000000, 1'b1, 32'h00000200, F, 32'h00000000, 1'b0},
      '{F, F, 32'h00000000, 1'b0, 32'h0,        32'h0, 32'h00000000, 1'b0},
      '{F, F, 32'h00000001, 1'b1, 32'h00000001, 32'h0, 32'h00000001, 1'b0},
      '{32'hFFFF0000, 32'hFF000000, 32'h00000000, 1'b1, F, 32'h0, 32'h00000000, 1'b0},
      '{32'hFFFF0000, 32'hFF000000, F,            1'b0, 32'h0, 32'h0, F, 1'b0},
      '{32'hFFFF0000, 32'hFF000000, 32'h0F0F0F0F, 1'b1, F, 32'h0, 32'hF0000F0F, 1'b0}
   };

   function automatic string tag_of(input int i);
      if (i < 5)       return "R4";
      else if (i < 8)  return "R3";
      else if (i == 11) return "R6";
      else if (i < 13) return "R2";
      else if (i < 18) return "R7";
      else if (i < 20) return "R6";
      else if (i == 3 || i == 4) return "R5";
      return "R8";
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state, inputs busy
      din = 32'hFFFF0000; evtyp = F; evbe = F;
      repeat (3) @(negedge clk);
      chk("R1", "status in reset", status, 32'h0);
      chk("R1", "irq in reset", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         evtyp = TBL[i].typ; evbe = TBL[i].be; din = TBL[i].d;
         st_wr = TBL[i].wr; st_wdata = TBL[i].wd; even = TBL[i].en;
         @(posedge clk); #1;
         chk(tag_of(i), $sformatf("row %0d status", i), status, TBL[i].st);
         chk(tag_of(i), $sformatf("row %0d irq", i), {31'b0, irq}, {31'b0, TBL[i].iq});
      end
      // W1C with zero bits untouched was covered in rows 3 and 4 (R5)
      chk("R5", "clear leaves unwritten bits", status & 32'h0000F0F0, 32'h00000000);

      // R7: irq follows enable without a clock edge (status F0000F0F)
      @(negedge clk);
      st_wr = 1'b0; din = 32'h0F0F0F0F; even = 32'h0;
      #1 chk("R7", "irq enable off", {31'b0, irq}, 32'h0);
      even = 32'h00000100;
      #1 chk("R7", "irq enable on", {31'b0, irq}, 32'h1);
      even = 32'h00F0F000;
      #1 chk("R7", "irq enable on clear bits", {31'b0, irq}, 32'h0);

      // R1: no false edge when inputs are high through reset
      @(negedge clk);
      rst_n = 1'b0; evtyp = F; evbe = F; din = F; even = F; st_wr = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1", "first cycle after reset", status, 32'h0);
      @(posedge clk); #1;
      chk("R1", "second cycle after reset", status, 32'h0);
      chk("R1", "irq after reset", {31'b0, irq}, 32'h0);

      finish_run();
   end

endmodule